// File: doc/BRIEF.md
# DSP-Mode Privilege and Exception Checker

This block sits next to a processor's decode and memory-access stages and decides, cycle by cycle, whether the current operation must raise an exception. Its decisions depend on two inputs: the DSP-enable bit from the status register and the current privilege mode. When the DSP bit is set, user code may execute the DSP instruction class, may read and write a small set of status-register fields, and may reach one 16 MiB window in the upper half of the address space without faulting.

The block also holds the status register. It applies privileged writes in full and masks user writes so that only the loop-count, modulo-addressing and repeat-flag fields change. Beside this it tracks the repeat-control period of a hardware loop. That period runs from the repeat-detection instruction through the repeat-end instruction, and only while the loop counter is non-zero. During the period the block reports the instruction's position relative to the detection point and asserts an interrupt-inhibit flag. Exception vectoring, translation and the DSP datapath are outside this block.

Top module: `dspx_guard`

## Requirements
- R1: An instruction of class DSP (`inst_cls` = 1) raises `ill_inst` when `dsp_en` is 0 and raises nothing when `dsp_en` is 1.
- R2: A status-register access (class 2 = write, class 3 = read) raises `ill_inst` when `user_mode` is 1 and `dsp_en` is 0. It is allowed in user mode with `dsp_en` 1 and always allowed in privileged mode. `sr_wr_ok` is 1 exactly for an allowed class-2 instruction.
- R3: An allowed status-register write in privileged mode loads all 32 bits of `sr_wdata` into `sr_q` at the next clock edge.
- R4: An allowed status-register write in user mode updates only bits 27:16 (loop count), 11 and 10 (modulo-addressing selects) and 3:2 (repeat flags), mask 0x0FFF0C0C. Every other bit keeps its value, including bit 12 (DSP enable) and bit 30 (privilege).
- R5: A rejected status-register write leaves `sr_q` unchanged.
- R6: `addr_err` is 1 when `acc_valid` is 1, `user_mode` is 1 and `acc_addr[31]` is 1, except when `dsp_en` is 1 and the address lies in 0xA5000000 through 0xA5FFFFFF. Privileged accesses never raise it.
- R7: While `rst_n` is low, `sr_q` is 0 (DSP bit clear), `rpt_active` and `int_inhibit` are 0 and `rpt_pos` is 0.
- R8: A valid instruction with `rpt_detect` set while `loop_cnt` is non-zero opens the repeat-control period. `rpt_active` is 1 from that instruction through the valid instruction carrying `rpt_end`, both included, and 0 afterwards. `int_inhibit` follows `rpt_active`.
- R9: Inside the period, `rpt_pos` is 0 for the detection instruction and 1, 2 and 3 for the next three valid instructions. It is 4 for every later one and 0 outside the period. Bubbles (`inst_valid` 0) do not advance it.
- R10: While `loop_cnt` is 0, no period is open, and an open period closes at once.
- R11: With `inst_valid` 0, `ill_inst` and `sr_wr_ok` are 0 and `sr_q` holds. With `acc_valid` 0, `addr_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| inst_valid | input | 1 | Decoded instruction present this cycle |
| inst_cls | input | 2 | Instruction class: 0 plain, 1 DSP, 2 SR write, 3 SR read |
| user_mode | input | 1 | 1 = user mode, 0 = privileged |
| dsp_en | input | 1 | DSP-enable bit of the status register |
| sr_wdata | input | 32 | Value offered by a status-register write |
| acc_valid | input | 1 | Data access present this cycle |
| acc_addr | input | 32 | Effective address of the access |
| rpt_detect | input | 1 | Instruction is the repeat-detection point |
| rpt_end | input | 1 | Instruction is the repeat-end point |
| loop_cnt | input | 12 | Current repeat counter |
| ill_inst | output | 1 | Illegal-instruction or privilege exception |
| addr_err | output | 1 | CPU address error |
| sr_wr_ok | output | 1 | Status-register write accepted |
| sr_q | output | 32 | Status register contents |
| rpt_active | output | 1 | Repeat-control period active |
| rpt_pos | output | 3 | Position within the period, saturating at 4 |
| int_inhibit | output | 1 | Hold off maskable interrupts |

## Verification
On every cycle the assertions check the following. A DSP instruction with the bit set never faults. Privileged accesses never raise an address error. Idle cycles raise nothing. A privileged write lands whole, while a user write never touches the DSP or privilege bits, and a rejected write holds the register. A zero loop counter keeps the period closed, and the position stays zero and bounded outside it. Only the bench's sweeps show the exact masked register value after user writes, the fault decision at each boundary of the address window, and the position sequence across loops of one to seven instructions with bubbles and an early counter drop.

// File: rtl/dspx_pkg.sv
package dspx_pkg;

  localparam int SR_W     = 32;
  localparam int SR_RC_LO = 16;
  localparam int SR_RC_W  = 12;
  localparam int SR_MD    = 30;
  localparam int SR_DSP   = 12;
  localparam int SR_DMY   = 11;
  localparam int SR_DMX   = 10;
  localparam int SR_RF_LO = 2;
  localparam int SR_RF_W  = 2;

  typedef enum logic [1:0] {
    CLS_PLAIN = 2'd0,
    CLS_DSP   = 2'd1,
    CLS_SR_WR = 2'd2,
    CLS_SR_RD = 2'd3
  } ins_cls_e;

  // Fields a user-mode write may change while the DSP bit is set.
  function automatic logic [SR_W-1:0] sr_user_mask();
    logic [SR_W-1:0] m;
    m = '0;
    m[SR_RC_LO +: SR_RC_W] = '1;
    m[SR_DMY]              = 1'b1;
    m[SR_DMX]              = 1'b1;
    m[SR_RF_LO +: SR_RF_W] = '1;
    return m;
  endfunction

  localparam logic [SR_W-1:0] SR_USR_MASK = sr_user_mask();

endpackage

// File: rtl/dspx_priv_check.sv
module dspx_priv_check
  import dspx_pkg::*;
#(
  parameter int                ADDR_W = 32,
  parameter logic [ADDR_W-1:0] WIN_LO = 32'hA500_0000,
  parameter logic [ADDR_W-1:0] WIN_HI = 32'hA5FF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inst_valid,
  input  ins_cls_e          cls,
  input  logic              user_mode,
  input  logic              dsp_en,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              ill_inst,
  output logic              addr_err,
  output logic              sr_wr_ok
);

  logic cls_dsp;
  logic cls_sr;
  logic dsp_ill;
  logic sr_ill;
  logic upper_half;
  logic in_window;
  logic window_open;

  always_comb begin
    cls_dsp = (cls == CLS_DSP);
    cls_sr  = (cls == CLS_SR_WR) || (cls == CLS_SR_RD);

    // DSP class needs the enable bit regardless of mode.
    dsp_ill = inst_valid && cls_dsp && !dsp_en;
    // SR access from user code is privileged unless DSP mode is on.
    sr_ill  = inst_valid && cls_sr && user_mode && !dsp_en;

    ill_inst = dsp_ill || sr_ill;
    sr_wr_ok = inst_valid && (cls == CLS_SR_WR) && !sr_ill;
  end

  always_comb begin
    upper_half  = acc_addr[ADDR_W-1];
    in_window   = (acc_addr >= WIN_LO) && (acc_addr <= WIN_HI);
    window_open = dsp_en && in_window;
    addr_err    = acc_valid && user_mode && upper_half && !window_open;
  end

  a_r1_dsp_allowed: assert property (@(posedge clk) disable iff (!rst_n)
    (inst_valid && cls == CLS_DSP && dsp_en) |-> !ill_inst);

  a_r6_priv_never_faults: assert property (@(posedge clk) disable iff (!rst_n)
    !user_mode |-> !addr_err);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !inst_valid |-> (!ill_inst && !sr_wr_ok));

  a_r2_accept_or_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !(sr_wr_ok && ill_inst));

endmodule

// File: rtl/dspx_sr_reg.sv
module dspx_sr_reg
  import dspx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_ok,
  input  logic            user_mode,
  input  logic [SR_W-1:0] wdata,
  output logic [SR_W-1:0] sr_q
);

  logic [SR_W-1:0] sr_d;
  logic            sr_en;

  always_comb begin
    sr_en = wr_ok;
    if (user_mode) begin
      sr_d = (sr_q & ~SR_USR_MASK) | (wdata & SR_USR_MASK);
    end else begin
      sr_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (sr_en) begin
      sr_q <= sr_d;
    end
  end

  a_r3_full_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && !user_mode) |=> (sr_q == $past(wdata)));

  a_r4_protected_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && user_mode) |=>
      (sr_q[SR_DSP] == $past(sr_q[SR_DSP])) && (sr_q[SR_MD] == $past(sr_q[SR_MD])));

endmodule

// File: rtl/dspx_rpt_track.sv
module dspx_rpt_track #(
  parameter int CNT_W   = 12,
  parameter int POS_SAT = 4,
  localparam int POS_W  = $clog2(POS_SAT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inst_valid,
  input  logic             rpt_detect,
  input  logic             rpt_end,
  input  logic [CNT_W-1:0] loop_cnt,
  output logic             active,
  output logic [POS_W-1:0] pos
);

  localparam logic [POS_W-1:0] POS_TOP = POS_W'(POS_SAT);

  logic             act_q;
  logic             act_d;
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_d;
  logic [POS_W-1:0] pos_inc;
  logic             st_en;
  logic             cnt_nz;
  logic             start;

  always_comb begin
    cnt_nz = |loop_cnt;
    start  = inst_valid && rpt_detect && cnt_nz;
    active = (act_q || start) && cnt_nz;
    if (!active || start) begin
      pos = '0;
    end else begin
      pos = pos_q;
    end
    pos_inc = (pos == POS_TOP) ? pos : pos + 1'b1;
  end

  always_comb begin
    act_d = act_q;
    pos_d = pos_q;
    st_en = 1'b0;
    if (!cnt_nz) begin
      st_en = 1'b1;
      act_d = 1'b0;
      pos_d = '0;
    end else if (active && inst_valid) begin
      st_en = 1'b1;
      if (rpt_end) begin
        act_d = 1'b0;
        pos_d = '0;
      end else begin
        act_d = 1'b1;
        pos_d = pos_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      pos_q <= '0;
    end else if (st_en) begin
      act_q <= act_d;
      pos_q <= pos_d;
    end
  end

  a_r10_zero_count_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_cnt == '0) |-> !active);

  a_r9_pos_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (pos == '0));

  a_r9_pos_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= POS_TOP);

  a_r8_end_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (active && inst_valid && rpt_end) |=> (!active || (inst_valid && rpt_detect)));

endmodule

// File: rtl/dspx_guard.sv
module dspx_guard
  import dspx_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 12,
  parameter int POS_SAT = 4,
  localparam int POS_W  = $clog2(POS_SAT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inst_valid,
  input  logic [1:0]        inst_cls,
  input  logic              user_mode,
  input  logic              dsp_en,
  input  logic [SR_W-1:0]   sr_wdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              rpt_detect,
  input  logic              rpt_end,
  input  logic [CNT_W-1:0]  loop_cnt,
  output logic              ill_inst,
  output logic              addr_err,
  output logic              sr_wr_ok,
  output logic [SR_W-1:0]   sr_q,
  output logic              rpt_active,
  output logic [POS_W-1:0]  rpt_pos,
  output logic              int_inhibit
);

  ins_cls_e cls;

  assign cls = ins_cls_e'(inst_cls);

  dspx_priv_check #(
    .ADDR_W (ADDR_W)
  ) u_priv (
    .clk        (clk),
    .rst_n      (rst_n),
    .inst_valid (inst_valid),
    .cls        (cls),
    .user_mode  (user_mode),
    .dsp_en     (dsp_en),
    .acc_valid  (acc_valid),
    .acc_addr   (acc_addr),
    .ill_inst   (ill_inst),
    .addr_err   (addr_err),
    .sr_wr_ok   (sr_wr_ok)
  );

  dspx_sr_reg u_sr (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ok     (sr_wr_ok),
    .user_mode (user_mode),
    .wdata     (sr_wdata),
    .sr_q      (sr_q)
  );

  dspx_rpt_track #(
    .CNT_W   (CNT_W),
    .POS_SAT (POS_SAT)
  ) u_rpt (
    .clk        (clk),
    .rst_n      (rst_n),
    .inst_valid (inst_valid),
    .rpt_detect (rpt_detect),
    .rpt_end    (rpt_end),
    .loop_cnt   (loop_cnt),
    .active     (rpt_active),
    .pos        (rpt_pos)
  );

  assign int_inhibit = rpt_active;

  a_r5_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (inst_valid && cls == CLS_SR_WR && ill_inst) |=> $stable(sr_q));

  a_r11_no_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !inst_valid |=> $stable(sr_q));

endmodule

// File: tb/sim_dspx_guard.sv
module sim_dspx_guard;

  localparam logic [31:0] MASK = 32'h0FFF_0C0C;

  logic        clk;
  logic        rst_n;
  logic        inst_valid;
  logic [1:0]  inst_cls;
  logic        user_mode;
  logic        dsp_en;
  logic [31:0] sr_wdata;
  logic        acc_valid;
  logic [31:0] acc_addr;
  logic        rpt_detect;
  logic        rpt_end;
  logic [11:0] loop_cnt;
  logic        ill_inst;
  logic        addr_err;
  logic        sr_wr_ok;
  logic [31:0] sr_q;
  logic        rpt_active;
  logic [2:0]  rpt_pos;
  logic        int_inhibit;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [31:0] m_sr;
  logic        m_act;
  logic [2:0]  m_pos;

  dspx_guard u0 (
    .clk (clk), .rst_n (rst_n), .inst_valid (inst_valid), .inst_cls (inst_cls),
    .user_mode (user_mode), .dsp_en (dsp_en), .sr_wdata (sr_wdata),
    .acc_valid (acc_valid), .acc_addr (acc_addr), .rpt_detect (rpt_detect),
    .rpt_end (rpt_end), .loop_cnt (loop_cnt), .ill_inst (ill_inst),
    .addr_err (addr_err), .sr_wr_ok (sr_wr_ok), .sr_q (sr_q),
    .rpt_active (rpt_active), .rpt_pos (rpt_pos), .int_inhibit (int_inhibit)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    inst_valid = 0; inst_cls = 0; user_mode = 0; dsp_en = 0; sr_wdata = 0;
    acc_valid = 0; acc_addr = 0; rpt_detect = 0; rpt_end = 0; loop_cnt = 0;
  endtask

  // Inputs are set at a falling edge; this checks combinational outputs,
  // crosses one rising edge, then checks the register at the next falling edge.
  task automatic run_cycle();
    logic e_ill, e_wok, e_aerr, cnz, st, e_act;
    logic [2:0] e_pos;
    string t_ill, t_rpt, t_sr;
    #1;
    e_ill  = inst_valid && ((inst_cls == 2'd1 && !dsp_en) ||
             (inst_cls[1] && user_mode && !dsp_en));
    e_wok  = inst_valid && inst_cls == 2'd2 && (!user_mode || dsp_en);
    e_aerr = acc_valid && user_mode && acc_addr[31] &&
             !(dsp_en && acc_addr >= 32'hA500_0000 && acc_addr <= 32'hA5FF_FFFF);
    cnz    = (loop_cnt != 0);
    st     = inst_valid && rpt_detect && cnz;
    e_act  = (m_act || st) && cnz;
    e_pos  = (e_act && !st) ? m_pos : 3'd0;
    t_ill  = !inst_valid ? "R11 ill_inst" : (inst_cls == 2'd1) ? "R1 ill_inst" : "R2 ill_inst";
    t_rpt  = !cnz ? "R10" : "R8";
    chk(ill_inst === e_ill, t_ill, 32'(ill_inst), 32'(e_ill));
    chk(sr_wr_ok === e_wok, "R2 sr_wr_ok", 32'(sr_wr_ok), 32'(e_wok));
    chk(addr_err === e_aerr, acc_valid ? "R6 addr_err" : "R11 addr_err", 32'(addr_err), 32'(e_aerr));
    chk(rpt_active === e_act, {t_rpt, " rpt_active"}, 32'(rpt_active), 32'(e_act));
    chk(int_inhibit === e_act, "R8 int_inhibit", 32'(int_inhibit), 32'(e_act));
    chk(rpt_pos === e_pos, "R9 rpt_pos", 32'(rpt_pos), 32'(e_pos));
    @(posedge clk);
    if (e_wok) m_sr = user_mode ? ((m_sr & ~MASK) | (sr_wdata & MASK)) : sr_wdata;
    if (!cnz) begin
      m_act = 0; m_pos = 0;
    end else if (e_act && inst_valid) begin
      if (rpt_end) begin
        m_act = 0; m_pos = 0;
      end else begin
        m_act = 1; m_pos = (e_pos == 3'd4) ? e_pos : e_pos + 3'd1;
      end
    end
    t_sr = !e_wok ? "R5 sr_q" : user_mode ? "R4 sr_q" : "R3 sr_q";
    @(negedge clk);
    chk(sr_q === m_sr, t_sr, sr_q, m_sr);
  endtask

  task automatic rpt_instr(input bit v, input bit det, input bit en);
    idle_inputs();
    loop_cnt = 12'd5; inst_valid = v; rpt_detect = det; rpt_end = en;
    run_cycle();
  endtask

  // Loop of len instructions; optional bubble after the detection point.
  task automatic rpt_loop(input int len, input bit bubble);
    rpt_instr(1, 0, 0);
    rpt_instr(1, 1, len == 1);
    if (bubble) rpt_instr(0, 0, 0);
    for (int k = 1; k < len; k++) rpt_instr(1, 0, k == len - 1);
    rpt_instr(1, 0, 0);
    rpt_instr(1, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [3];
    logic [31:0] addrs [10];
    pats  = '{32'hFFFF_FFFF, 32'h5A5A_A5A5, 32'h0000_0000};
    addrs = '{32'h0000_0000, 32'h7FFF_FFFF, 32'h8000_0000, 32'hA4FF_FFFF,
              32'hA500_0000, 32'hA580_1234, 32'hA5FF_FFFF, 32'hA600_0000,
              32'hFFFF_FFFF, 32'h1234_5678};
    idle_inputs();
    rst_n = 0;
    m_sr = 0; m_act = 0; m_pos = 0;
    repeat (3) @(negedge clk);
    // R7: reset state
    chk(sr_q === 32'h0, "R7 sr_q", sr_q, 32'h0);
    chk(rpt_active === 1'b0, "R7 rpt_active", 32'(rpt_active), 0);
    chk(int_inhibit === 1'b0, "R7 int_inhibit", 32'(int_inhibit), 0);
    chk(rpt_pos === 3'd0, "R7 rpt_pos", 32'(rpt_pos), 0);
    rst_n = 1;
    @(negedge clk);

    // R1 R2 R3 R4 R5 R11: every class, mode, enable and valid combination
    for (int p = 0; p < 3; p++)
      for (int c = 0; c < 4; c++)
        for (int u = 0; u < 2; u++)
          for (int d = 0; d < 2; d++)
            for (int v = 0; v < 2; v++) begin
              idle_inputs();
              inst_valid = 1; inst_cls = 2'd2; sr_wdata = 32'hC3C3_3C3C ^ pats[p];
              run_cycle();
              idle_inputs();
              inst_valid = v[0]; inst_cls = c[1:0]; user_mode = u[0]; dsp_en = d[0];
              sr_wdata = pats[p];
              run_cycle();
            end

    // R6: address window boundaries
    for (int a = 0; a < 10; a++)
      for (int u = 0; u < 2; u++)
        for (int d = 0; d < 2; d++)
          for (int av = 0; av < 2; av++) begin
            idle_inputs();
            acc_addr = addrs[a]; user_mode = u[0]; dsp_en = d[0]; acc_valid = av[0];
            run_cycle();
          end

    // R8 R9: loops of several lengths, with and without bubbles
    rpt_loop(1, 0);
    rpt_loop(2, 0);
    rpt_loop(3, 1);
    rpt_loop(4, 0);
    rpt_loop(7, 1);

    // R10: detection with a zero counter opens nothing
    idle_inputs(); inst_valid = 1; rpt_detect = 1; loop_cnt = 0; run_cycle();
    idle_inputs(); inst_valid = 1; loop_cnt = 0; run_cycle();
    // R10: counter drops to zero inside an open period
    rpt_instr(1, 1, 0);
    rpt_instr(1, 0, 0);
    idle_inputs(); inst_valid = 1; loop_cnt = 0; run_cycle();
    rpt_instr(1, 0, 0);
    rpt_instr(1, 0, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule